// File: doc/BRIEF.md
# Six-Switch Driver Control with Fault Status

This block is the digital core of a driver for three half-bridges. It holds a 16-bit control word, which an upstream serial receiver loads with a one-cycle strobe. From that word and an external PWM input it derives six switch enables, indexed 0 to 5 in the order low-1, high-1, low-2, high-2, low-3, high-3. Switches 2k and 2k+1 form half-bridge k.

Each switch has its own small state machine with three states. In SW_OFF the enable is low. In SW_ON the enable is high. In SW_TRIP the switch has been latched off by an overload. The transitions are named as follows:
- SW_OFF→SW_ON (`arm`) when the switch's effective request is high.
- SW_ON→SW_OFF (`drop`) when that request goes low.
- SW_ON→SW_TRIP (`trip`) on an overload while shutdown latching is enabled.
- SW_TRIP→SW_OFF (`release`) when the control word is loaded with the switch's on bit cleared or with the clear bit set.

The block also builds a 16-bit status word from fault inputs that the analog side samples. These are per-switch overload events, per-switch open-load flags, a temperature prewarning and supply undervoltage. The overload and undervoltage flags are sticky and clear on command.

Top module: `sixsw_ctrl`

## Requirements
- R1: `ctrl_load` high captures `ctrl_word` on that clock edge. The reset value is 16'hE000. Control bit 1+i high requests switch i. `gate_en[i]` follows the captured word one clock after capture.
- R2: Control bit 7+i high puts switch i under PWM. Such a switch is on only while `pwm_in` is high, and `gate_en` follows `pwm_in` with one clock of latency.
- R3: Control bit 15 low is standby. In standby all of `gate_en` is 0 and status bit 14 reads 1; status bit 14 is the inverse of control bit 15.
- R4: If both switches of a half-bridge are requested, both enables are forced to 0. Two switches of the same pair are never on together.
- R5: With control bit 14 high, an overload event on an on switch latches it off. It stays off until a load either clears its on bit or sets control bit 0.
- R6: With control bit 14 low, an overload event does not latch the switch off.
- R7: Status bit 13 sets one clock after any overload event input is high. It is cleared by a load with control bit 0 high; if an event arrives in the same cycle, the set wins.
- R8: Status bit 15 sets one clock after `supply_uv` is high. It holds until cleared the same way as R7.
- R9: With control bit 13 low, status bits 1 to 6 give the registered `open_load` flags, and the clear bit does not affect them. With control bit 13 high, they give `gate_en`. Status bit 0 is the registered `temp_warn`, and bits 7 to 12 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 16 | Control word from the serial receiver |
| ctrl_load | input | 1 | One-cycle strobe that captures `ctrl_word` |
| pwm_in | input | 1 | External PWM signal |
| ovl_evt | input | 6 | Per-switch overload event (short circuit or overtemperature) |
| open_load | input | 6 | Per-switch open-load flags |
| temp_warn | input | 1 | Temperature prewarning |
| supply_uv | input | 1 | Supply undervoltage |
| gate_en | output | 6 | Switch enables, index 0..5 = low-1, high-1, low-2, high-2, low-3, high-3 |
| status_word | output | 16 | Assembled status word |

## Verification
On every cycle, the assertions check three things: that no half-bridge has both enables high, that standby keeps the enables low, and that the unused status bits stay zero. They also check, one cycle after the cause, that the sticky flags are set and that the standby status bit matches the last loaded word. Only the directed scenarios can show the rest. That covers the exact latency of control and PWM changes, the latch and release of a tripped switch, the choice of status source in each mode, and the set-wins-over-clear ordering.

// File: rtl/sixsw_pkg.sv
package sixsw_pkg;
    localparam int NUM_PAIRS = 3;
    localparam int NUM_SW    = 2 * NUM_PAIRS;
    localparam int CTRL_W    = 16;

    // control word fields
    localparam int CLR_BIT   = 0;
    localparam int ON_BASE   = CLR_BIT + 1;
    localparam int PWM_BASE  = ON_BASE + NUM_SW;
    localparam int OLD_BIT   = PWM_BASE + NUM_SW;
    localparam int OCS_BIT   = OLD_BIT + 1;
    localparam int SI_BIT    = OCS_BIT + 1;
    localparam logic [CTRL_W-1:0] CTRL_RST = 16'hE000;

    // status word fields
    localparam int TW_BIT    = 0;
    localparam int ST_BASE   = TW_BIT + 1;
    localparam int OVL_BIT   = 13;
    localparam int INH_BIT   = 14;
    localparam int PSF_BIT   = 15;

    typedef enum logic [1:0] {
        SW_OFF  = 2'd0,
        SW_ON   = 2'd1,
        SW_TRIP = 2'd2
    } sw_state_e;
endpackage

// File: rtl/sixsw_lane.sv
module sixsw_lane
    import sixsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic ovl,
    input  logic latch_en,
    input  logic release_req,
    output logic gate
);
    sw_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SW_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_OFF:  if (req) state_d = SW_ON;                    // arm
            SW_ON: begin
                if (ovl && latch_en) state_d = SW_TRIP;           // trip
                else if (!req)       state_d = SW_OFF;            // drop
            end
            SW_TRIP: if (release_req) state_d = SW_OFF;           // release
            default: state_d = SW_OFF;
        endcase
    end

    always_comb begin
        gate = (state_q == SW_ON);
    end
endmodule

// File: rtl/sixsw_sticky.sv
module sixsw_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // set has priority so an event coinciding with a clear is kept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/sixsw_status.sv
module sixsw_status
    import sixsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SW-1:0] gate_en,
    input  logic [NUM_SW-1:0] open_load,
    input  logic              temp_warn,
    input  logic              ol_mode_n,
    input  logic              run_en,
    input  logic              ovl_flag,
    input  logic              uv_flag,
    output logic [CTRL_W-1:0] status_word
);
    logic [NUM_SW-1:0] ol_q;
    logic              tw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ol_q <= '0;
            tw_q <= 1'b0;
        end else begin
            ol_q <= open_load;
            tw_q <= temp_warn;
        end
    end

    always_comb begin
        status_word = '0;
        status_word[TW_BIT] = tw_q;
        status_word[ST_BASE +: NUM_SW] = ol_mode_n ? gate_en : ol_q;
        status_word[OVL_BIT] = ovl_flag;
        status_word[INH_BIT] = ~run_en;
        status_word[PSF_BIT] = uv_flag;
    end
endmodule

// File: rtl/sixsw_ctrl.sv
module sixsw_ctrl
    import sixsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              ctrl_load,
    input  logic              pwm_in,
    input  logic [NUM_SW-1:0] ovl_evt,
    input  logic [NUM_SW-1:0] open_load,
    input  logic              temp_warn,
    input  logic              supply_uv,
    output logic [NUM_SW-1:0] gate_en,
    output logic [CTRL_W-1:0] status_word
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [NUM_SW-1:0] raw_req;
    logic [NUM_SW-1:0] eff_req;
    logic              clr_cmd;
    logic              ovl_flag;
    logic              uv_flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ctrl_q <= CTRL_RST;
        else if (ctrl_load) ctrl_q <= ctrl_word;
    end

    assign clr_cmd = ctrl_load & ctrl_word[CLR_BIT];

    for (genvar i = 0; i < NUM_SW; i++) begin : g_req
        assign raw_req[i] = ctrl_q[SI_BIT] & ctrl_q[ON_BASE + i]
                          & (~ctrl_q[PWM_BASE + i] | pwm_in);
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        assign eff_req[2*p]   = raw_req[2*p]   & ~raw_req[2*p+1];
        assign eff_req[2*p+1] = raw_req[2*p+1] & ~raw_req[2*p];
    end

    for (genvar i = 0; i < NUM_SW; i++) begin : g_lane
        sixsw_lane u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .req        (eff_req[i]),
            .ovl        (ovl_evt[i]),
            .latch_en   (ctrl_q[OCS_BIT]),
            .release_req(ctrl_load & (~ctrl_word[ON_BASE + i] | ctrl_word[CLR_BIT])),
            .gate       (gate_en[i])
        );
    end

    sixsw_sticky u_ovl (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (|ovl_evt),
        .clr  (clr_cmd),
        .flag (ovl_flag)
    );

    sixsw_sticky u_uv (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (supply_uv),
        .clr  (clr_cmd),
        .flag (uv_flag)
    );

    sixsw_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_en    (gate_en),
        .open_load  (open_load),
        .temp_warn  (temp_warn),
        .ol_mode_n  (ctrl_q[OLD_BIT]),
        .run_en     (ctrl_q[SI_BIT]),
        .ovl_flag   (ovl_flag),
        .uv_flag    (uv_flag),
        .status_word(status_word)
    );
endmodule

// File: rtl/sixsw_ctrl_chk.sv
module sixsw_ctrl_chk
    import sixsw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] ctrl_word,
    input logic              ctrl_load,
    input logic              pwm_in,
    input logic [NUM_SW-1:0] ovl_evt,
    input logic [NUM_SW-1:0] open_load,
    input logic              temp_warn,
    input logic              supply_uv,
    input logic [NUM_SW-1:0] gate_en,
    input logic [CTRL_W-1:0] status_word
);
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair_chk
        // R4
        no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_en[2*p] && gate_en[2*p+1]));
    end

    // R3
    standby_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_word[INH_BIT]) && status_word[INH_BIT]) |-> (gate_en == '0));

    // R3
    inhibit_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_load) |-> (status_word[INH_BIT] == !$past(ctrl_word[SI_BIT])));

    // R7
    ovl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovl_evt != '0) |-> status_word[OVL_BIT]);

    // R8
    uv_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(supply_uv) |-> status_word[PSF_BIT]);

    // R9
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[12:7] == 6'd0);
endmodule

bind sixsw_ctrl sixsw_ctrl_chk u_chk (.*);

// File: tb/sixsw_ctrl_test.sv
module sixsw_ctrl_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ctrl_word = 16'h0;
    logic        ctrl_load = 1'b0;
    logic        pwm_in = 1'b0;
    logic [5:0]  ovl_evt = 6'h0;
    logic [5:0]  open_load = 6'h0;
    logic        temp_warn = 1'b0;
    logic        supply_uv = 1'b0;
    logic [5:0]  gate_en;
    logic [15:0] status_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [15:0] SI  = 16'h8000;
    localparam logic [15:0] OCS = 16'h4000;
    localparam logic [15:0] OLD = 16'h2000;
    localparam logic [15:0] CLR = 16'h0001;

    always #(CLK_P/2) clk = ~clk;

    sixsw_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .ctrl_load(ctrl_load),
        .pwm_in(pwm_in), .ovl_evt(ovl_evt), .open_load(open_load),
        .temp_warn(temp_warn), .supply_uv(supply_uv),
        .gate_en(gate_en), .status_word(status_word)
    );

    function automatic logic [15:0] on_bit(int i);
        return 16'h1 << (1 + i);
    endfunction

    function automatic logic [15:0] pwm_bit(int i);
        return 16'h1 << (7 + i);
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // drive at a negedge, capture on the next posedge, return at the following negedge
    task automatic load(input logic [15:0] w);
        ctrl_word = w;
        ctrl_load = 1'b1;
        cyc();
        ctrl_load = 1'b0;
    endtask

    task automatic t_reset();
        check(gate_en == 6'h0, "R1", {10'h0, gate_en}, 16'h0);
        check(status_word == 16'h0, "R1", status_word, 16'h0);
    endtask

    task automatic t_direct_on();
        load(SI | OCS | OLD | on_bit(0) | on_bit(3) | on_bit(5));
        check(gate_en == 6'h00, "R1", {10'h0, gate_en}, 16'h0);
        cyc();
        check(gate_en == 6'b101001, "R1", {10'h0, gate_en}, 16'h29);
        check(status_word[6:1] == 6'b101001, "R9", status_word, 16'h0052);
        load(SI | OCS | OLD | on_bit(2));
        cyc();
        check(gate_en == 6'b000100, "R1", {10'h0, gate_en}, 16'h04);
    endtask

    task automatic t_pwm();
        pwm_in = 1'b0;
        load(SI | OCS | OLD | on_bit(3) | pwm_bit(3) | on_bit(0));
        cyc();
        check(gate_en == 6'b000001, "R2", {10'h0, gate_en}, 16'h01);
        pwm_in = 1'b1;
        cyc();
        check(gate_en == 6'b001001, "R2", {10'h0, gate_en}, 16'h09);
        pwm_in = 1'b0;
        cyc();
        check(gate_en == 6'b000001, "R2", {10'h0, gate_en}, 16'h01);
    endtask

    task automatic t_standby();
        load(OCS | OLD | on_bit(0) | on_bit(3));
        check(status_word[14] == 1'b1, "R3", status_word, 16'h4000);
        cyc();
        check(gate_en == 6'h0, "R3", {10'h0, gate_en}, 16'h0);
        load(SI | OCS | OLD | on_bit(0) | on_bit(3));
        check(status_word[14] == 1'b0, "R3", status_word, 16'h0);
        cyc();
        check(gate_en == 6'b001001, "R3", {10'h0, gate_en}, 16'h09);
    endtask

    task automatic t_shoot();
        load(SI | OCS | OLD | on_bit(0) | on_bit(1) | on_bit(2));
        cyc();
        check(gate_en == 6'b000100, "R4", {10'h0, gate_en}, 16'h04);
        load(SI | OCS | OLD | on_bit(4) | on_bit(5) | pwm_bit(5));
        cyc();
        check(gate_en == 6'b010000, "R4", {10'h0, gate_en}, 16'h10);
        pwm_in = 1'b1;
        cyc();
        check(gate_en == 6'b000000, "R4", {10'h0, gate_en}, 16'h00);
        pwm_in = 1'b0;
    endtask

    task automatic t_latch();
        logic [15:0] w;
        w = SI | OCS | OLD | on_bit(1);
        load(w);
        cyc();
        check(gate_en == 6'b000010, "R5", {10'h0, gate_en}, 16'h02);
        ovl_evt = 6'b000010;
        cyc();
        ovl_evt = 6'h0;
        check(gate_en == 6'h0, "R5", {10'h0, gate_en}, 16'h0);
        check(status_word[13] == 1'b1, "R7", status_word, 16'h2000);
        cyc();
        check(gate_en == 6'h0, "R5", {10'h0, gate_en}, 16'h0);
        load(w);
        cyc();
        check(gate_en == 6'h0, "R5", {10'h0, gate_en}, 16'h0);
        load(w | CLR);
        cyc();
        check(gate_en == 6'b000010, "R5", {10'h0, gate_en}, 16'h02);
        check(status_word[13] == 1'b0, "R7", status_word, 16'h0);
        // release by clearing the on bit, then request again
        ovl_evt = 6'b000010;
        cyc();
        ovl_evt = 6'h0;
        load(SI | OCS | OLD);
        load(w);
        cyc();
        check(gate_en == 6'b000010, "R5", {10'h0, gate_en}, 16'h02);
    endtask

    task automatic t_no_latch();
        load(SI | OLD | CLR | on_bit(2));
        cyc();
        check(gate_en == 6'b000100, "R6", {10'h0, gate_en}, 16'h04);
        ovl_evt = 6'b000100;
        cyc();
        ovl_evt = 6'h0;
        cyc();
        check(gate_en == 6'b000100, "R6", {10'h0, gate_en}, 16'h04);
        check(status_word[13] == 1'b1, "R7", status_word, 16'h2000);
    endtask

    task automatic t_set_wins();
        ctrl_word = SI | OLD | CLR;
        ctrl_load = 1'b1;
        ovl_evt = 6'b100000;
        cyc();
        ctrl_load = 1'b0;
        ovl_evt = 6'h0;
        check(status_word[13] == 1'b1, "R7", status_word, 16'h2000);
        load(SI | OLD | CLR);
        check(status_word[13] == 1'b0, "R7", status_word, 16'h0);
    endtask

    task automatic t_uv();
        supply_uv = 1'b1;
        cyc();
        supply_uv = 1'b0;
        check(status_word[15] == 1'b1, "R8", status_word, 16'h8000);
        cyc(); cyc();
        check(status_word[15] == 1'b1, "R8", status_word, 16'h8000);
        load(SI | OLD | CLR);
        check(status_word[15] == 1'b0, "R8", status_word, 16'h0);
    endtask

    task automatic t_status_mode();
        open_load = 6'b101010;
        temp_warn = 1'b1;
        load(SI | OCS | on_bit(0));
        cyc();
        check(status_word[6:1] == 6'b101010, "R9", status_word, 16'h0054);
        check(status_word[0] == 1'b1, "R9", status_word, 16'h0001);
        load(SI | OCS | CLR | on_bit(0));
        check(status_word[6:1] == 6'b101010, "R9", status_word, 16'h0054);
        load(SI | OCS | OLD | on_bit(0));
        check(status_word[6:1] == 6'b000001, "R9", status_word, 16'h0002);
        check(status_word[12:7] == 6'h0, "R9", status_word, 16'h0);
        open_load = 6'h0;
        temp_warn = 1'b0;
        cyc();
        check(status_word[0] == 1'b0, "R9", status_word, 16'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_direct_on();
        t_pwm();
        t_standby();
        t_shoot();
        t_latch();
        t_no_latch();
        t_set_wins();
        t_uv();
        t_status_mode();
        finish_run();
    end
endmodule